// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs one 14-bit successive-approximation conversion each time it sees a rising edge on its start input. The start edge moves the track/hold control into hold. The edge is brought into the conversion clock domain, and the block then resolves the code one bit per clock, from the most significant bit down. At each step it presents a trial code to an external DAC/comparator pair and reads back a single comparator bit. When the last bit is settled, the block latches the result, pulses a done flag, returns the track/hold to track and waits out an acquisition period. Start edges that arrive during that period are ignored.

Two clocking situations are supported. With a continuously running clock, a half-cycle capture window decides how long the conversion takes. A start that rises while the clock is high is caught before the next rising edge, giving 19 edges. A start that rises while the clock is low misses that edge, giving 20. When the clock is known to start together with the request (direct start), the request is sampled straight away and the length is always 19 edges. A serial clock output is derived from the conversion clock. It either runs freely or is switched on only around the conversion.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, hold, busy and done are low, result and trial_code are zero, and sclk stays low while sclk_free is 0.
- R2: An accepted start edge raises hold and busy on the same clock edge, and trial_code becomes the most significant bit alone (0x2000) on that edge.
- R3: With direct_start = 0, edges are counted from the first rising clock edge after start_req rises, as edge 1. If start_req rises while clk is high, hold returns low on edge 19. If start_req rises while clk is low, hold returns low on edge 20.
- R4: With direct_start = 1, hold returns low on edge 19, whichever clock phase start_req rises in.
- R5: On each of the 14 trial edges, the current trial bit is kept when cmp_hi is 1 and cleared when it is 0, and the next lower bit is set. With a comparator giving cmp_hi = 1 exactly when trial_code <= target, result equals target.
- R6: done is high for exactly one cycle, on the edge before hold returns low. busy falls on that same edge, and result changes only on that edge.
- R7: While sclk_free is 1, sclk gives one rising edge for every rising edge of clk.
- R8: While sclk_free is 0, sclk gives exactly 15 rising edges per conversion. The first comes on the edge after hold rises and the last on the edge that raises done. There are none while idle.
- R9: A start edge that arrives while busy is high starts nothing.
- R10: A start edge detected during the ACQ_CYCLES (default 4) clock edges that follow hold returning low starts nothing. A start edge after that period is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Asynchronous conversion request; its rising edge counts |
| cmp_hi | input | 1 | Comparator result for the current trial code |
| direct_start | input | 1 | 1: clock starts with the request, so the half-cycle capture stage is skipped |
| sclk_free | input | 1 | 1: sclk runs always; 0: sclk runs only around a conversion |
| hold | output | 1 | Track/hold control, 1 = hold |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle end-of-conversion pulse |
| trial_code | output | 14 | Trial word presented to the external DAC |
| result | output | 14 | Latched conversion result |
| sclk | output | 1 | Serial clock derived from clk |

## Verification
The bench counts clock edges from the moment start_req rises and places that rise in either the high or the low phase of the clock. A capture window on the wrong edge would shift every timing point by one cycle in one of the two modes. Targets at all-zeros, all-ones, alternating bits and random values show whether each trial bit is kept or cleared correctly; an off-by-one in the bit pointer would give a wrong LSB or MSB. Retrigger pulses during a conversion and during acquisition would show up as a second hold rise or a second done pulse in a design that failed to block them. Counting sclk edges shows whether the gated serial clock gives one pulse too many or too few, or leaks while idle.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_TRACK   = 3'd0,
        SEQ_TRIAL   = 3'd1,
        SEQ_LATCH   = 3'd2,
        SEQ_RELEASE = 3'd3,
        SEQ_ACQ     = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic hold;
        logic busy;
        logic done;
    } seq_flags_t;

    localparam seq_flags_t FLAGS_IDLE = '{hold: 1'b0, busy: 1'b0, done: 1'b0};

    function automatic logic accepts_start(input seq_state_e s);
        return s == SEQ_TRACK;
    endfunction

endpackage

// File: rtl/sar_start_sync.sv
module sar_start_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_async,
    input  logic direct_start,
    output logic start_edge
);
    logic               half_q;
    logic               first_in;
    logic [SYNC_STAGES:0] chain_q;

    // half-cycle window: catches a request that rises while clk is high
    always_ff @(negedge clk) begin
        if (rst) half_q <= 1'b0;
        else     half_q <= start_async;
    end

    assign first_in = direct_start ? start_async : half_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[SYNC_STAGES-1:0], first_in};
    end

    assign start_edge = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int unsigned DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic              cmp_hi,
    output logic [DATA_W-1:0] code,
    output logic              last_bit
);
    localparam logic [DATA_W-1:0] MSB_ONLY = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code  <= '0;
            ptr_q <= '0;
        end else if (load) begin
            code  <= MSB_ONLY;
            ptr_q <= MSB_ONLY;
        end else if (step) begin
            code  <= (cmp_hi ? code : (code & ~ptr_q)) | (ptr_q >> 1);
            ptr_q <= ptr_q >> 1;
        end
    end

    assign last_bit = ptr_q[0];
endmodule

// File: rtl/sar_sclk_gate.sv
module sar_sclk_gate (
    input  logic clk,
    input  logic rst,
    input  logic free_run,
    input  logic active,
    output logic sclk
);
    logic en_q;

    // enable changes only while clk is low, so the gated clock has no runt pulse
    always_ff @(negedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= free_run | active;
    end

    assign sclk = clk & en_q;
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int unsigned DATA_W      = 14,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ACQ_CYCLES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic              cmp_hi,
    input  logic              direct_start,
    input  logic              sclk_free,
    output logic              hold,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] trial_code,
    output logic [DATA_W-1:0] result,
    output logic              sclk
);
    localparam int unsigned ACQ_W = $clog2(ACQ_CYCLES + 1);
    localparam logic [ACQ_W-1:0] ACQ_LOAD = ACQ_W'(ACQ_CYCLES - 1);

    seq_state_e       state_q;
    seq_flags_t       flags_q;
    logic [ACQ_W-1:0] acq_q;
    logic             start_edge;
    logic             load_trial;
    logic             step_trial;
    logic             last_bit;

    sar_start_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk),
        .rst          (rst),
        .start_async  (start_req),
        .direct_start (direct_start),
        .start_edge   (start_edge)
    );

    assign load_trial = accepts_start(state_q) & start_edge;
    assign step_trial = (state_q == SEQ_TRIAL);

    sar_trial_reg #(.DATA_W(DATA_W)) u_trial (
        .clk      (clk),
        .rst      (rst),
        .load     (load_trial),
        .step     (step_trial),
        .cmp_hi   (cmp_hi),
        .code     (trial_code),
        .last_bit (last_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_TRACK;
            flags_q <= FLAGS_IDLE;
            acq_q   <= '0;
            result  <= '0;
        end else begin
            flags_q.done <= 1'b0;
            unique case (state_q)
                SEQ_TRACK: begin
                    if (load_trial) begin
                        state_q      <= SEQ_TRIAL;
                        flags_q.hold <= 1'b1;
                        flags_q.busy <= 1'b1;
                    end
                end
                SEQ_TRIAL: begin
                    if (last_bit) state_q <= SEQ_LATCH;
                end
                SEQ_LATCH: begin
                    result       <= trial_code;
                    flags_q.done <= 1'b1;
                    flags_q.busy <= 1'b0;
                    state_q      <= SEQ_RELEASE;
                end
                SEQ_RELEASE: begin
                    flags_q.hold <= 1'b0;
                    acq_q        <= ACQ_LOAD;
                    state_q      <= SEQ_ACQ;
                end
                SEQ_ACQ: begin
                    if (acq_q == '0) state_q <= SEQ_TRACK;
                    else             acq_q   <= acq_q - 1'b1;
                end
                default: state_q <= SEQ_TRACK;
            endcase
        end
    end

    assign hold = flags_q.hold;
    assign busy = flags_q.busy;
    assign done = flags_q.done;

    sar_sclk_gate u_sclk (
        .clk      (clk),
        .rst      (rst),
        .free_run (sclk_free),
        .active   (flags_q.busy),
        .sclk     (sclk)
    );
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
    parameter int unsigned DATA_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              hold,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] trial_code,
    input logic [DATA_W-1:0] result
);
    localparam logic [DATA_W-1:0] MSB_ONLY = {1'b1, {(DATA_W-1){1'b0}}};

    AST_HOLD_WITH_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $rose(hold)); // R2

    AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> trial_code == MSB_ONLY); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6

    AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R6

    AST_TRACK_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> !hold); // R6

    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result)); // R6

    AST_HOLD_COVERS_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> hold); // R9
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hold       (hold),
    .busy       (busy),
    .done       (done),
    .trial_code (trial_code),
    .result     (result)
);

// File: tb/test_sar_conv_seq.sv
module test_sar_conv_seq;
    localparam int W = 14;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_req = 1'b0;
    logic         direct_start = 1'b0;
    logic         sclk_free = 1'b0;
    logic         hold, busy, done, sclk;
    logic [W-1:0] trial_code, result;
    logic [W-1:0] target = '0;
    logic         cmp_hi;

    int n_tests = 0;
    int n_fail  = 0;
    int sclk_cnt = 0;

    always #10 clk = ~clk;

    // behavioural comparator: input at or above the trial level keeps the bit
    assign cmp_hi = (trial_code <= target);

    always @(posedge sclk) sclk_cnt++;

    sar_conv_seq i_sar_conv_seq (
        .clk(clk), .rst(rst), .start_req(start_req), .cmp_hi(cmp_hi),
        .direct_start(direct_start), .sclk_free(sclk_free),
        .hold(hold), .busy(busy), .done(done),
        .trial_code(trial_code), .result(result), .sclk(sclk)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // retrig: extra start during busy (R9); acq_poke: start during acquisition (R10)
    task automatic do_conv(input bit gm, input bit low, input logic [W-1:0] tgt,
                           input bit free, input bit retrig, input bit acq_poke);
        int rise_at = 0, done_at = 0, fall_at = 0, rises = 0, dones = 0;
        int len;
        logic prev_hold = 1'b0;
        logic [W-1:0] res_at_done = '0;
        bit busy_ok_rise = 1'b1, busy_ok_done = 1'b1, msb_ok = 1'b1;
        len = (!gm && low) ? 20 : 19;
        direct_start = gm;
        sclk_free    = free;
        target       = tgt;
        @(negedge clk);
        if (low) @(negedge clk); else @(posedge clk);
        #3;
        sclk_cnt  = 0;
        start_req = 1'b1;
        for (int n = 1; n <= 40; n++) begin
            @(posedge clk);
            #1;
            if (n == 5) start_req = 1'b0;
            if (retrig && n == 8) start_req = 1'b1;
            if (retrig && n == 11) start_req = 1'b0;
            if (acq_poke && n == len + 1) start_req = 1'b1;
            if (acq_poke && n == len + 4) start_req = 1'b0;
            if (hold && !prev_hold) begin
                rises++;
                if (rise_at == 0) begin
                    rise_at = n;
                    busy_ok_rise = busy;
                    msb_ok = (trial_code == 14'h2000);
                end
            end
            if (!hold && prev_hold && fall_at == 0) fall_at = n;
            if (done) begin
                dones++;
                if (done_at == 0) begin
                    done_at = n;
                    res_at_done = result;
                    busy_ok_done = !busy;
                end
            end
            prev_hold = hold;
        end
        check(rise_at == len - 16, "R2 hold rise edge", rise_at, len - 16);
        check(busy_ok_rise && msb_ok, "R2 busy and MSB trial at hold rise", int'(busy_ok_rise), 1);
        if (gm) check(fall_at == len, "R4 hold fall edge", fall_at, len);
        else    check(fall_at == len, "R3 hold fall edge", fall_at, len);
        check(res_at_done == tgt, "R5 result", int'(res_at_done), int'(tgt));
        check(done_at == len - 1 && dones == 1, "R6 done edge", done_at, len - 1);
        check(busy_ok_done, "R6 busy low at done", int'(!busy_ok_done), 0);
        if (free) check(sclk_cnt == 40, "R7 free sclk edges", sclk_cnt, 40);
        else      check(sclk_cnt == 15, "R8 gated sclk edges", sclk_cnt, 15);
        if (retrig)   check(rises == 1, "R9 hold rises with retrigger", rises, 1);
        if (acq_poke) check(rises == 1, "R10 hold rises with start in acquisition", rises, 1);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        // R1 reset state
        check(!hold && !busy && !done, "R1 flags after reset", int'({hold, busy, done}), 0);
        check(result == '0 && trial_code == '0, "R1 data after reset", int'(result), 0);
        sclk_cnt = 0;
        repeat (5) @(posedge clk);
        #1 check(sclk_cnt == 0, "R1 R8 idle sclk", sclk_cnt, 0);

        // directed corners
        do_conv(1'b0, 1'b0, 14'h0000, 1'b0, 1'b0, 1'b0); // R3 19 edges
        do_conv(1'b0, 1'b1, 14'h3FFF, 1'b0, 1'b0, 1'b0); // R3 20 edges
        do_conv(1'b1, 1'b1, 14'h2AAA, 1'b0, 1'b0, 1'b0); // R4
        do_conv(1'b1, 1'b0, 14'h1555, 1'b1, 1'b0, 1'b0); // R7
        do_conv(1'b0, 1'b0, 14'h0001, 1'b0, 1'b1, 1'b0); // R9
        do_conv(1'b1, 1'b0, 14'h2000, 1'b0, 1'b0, 1'b1); // R10 poke ignored
        do_conv(1'b0, 1'b1, 14'h1FFF, 1'b0, 1'b0, 1'b0); // R10 accepted after acquisition

        sclk_free = 1'b0;
        @(negedge clk);
        sclk_cnt = 0;
        repeat (6) @(posedge clk);
        #1 check(sclk_cnt == 0, "R8 idle sclk after conversions", sclk_cnt, 0);

        // random mix
        for (int k = 0; k < 14; k++) begin
            logic [W-1:0] t;
            bit gm, low, free, rt;
            t    = W'($urandom);
            gm   = 1'($urandom);
            low  = 1'($urandom);
            free = 1'($urandom);
            rt   = 1'($urandom);
            do_conv(gm, low, t, free, rt, 1'b0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule